// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter driven by a selectable prescaler from the system clock, with one control/status byte. The counter rolls over from 0xFF to 0x00, and that rollover sets a sticky wrap flag. What the rollover does next depends on the mode. As a watchdog, it raises either an internal reset request or a non-maskable interrupt request. As an interval timer, it raises a level interrupt request that lasts while the flag is set and interrupts are enabled.

Software reaches the counter and the control byte over a small register bus. Every write carries a 16-bit word: the upper byte is a key and the lower byte is the data. A write with the wrong key is dropped. The wrap flag cannot be written to 1. Software clears it in two steps: it must first read the control byte while the flag reads 1, and only then write 0 to that bit. This stops a stray store from losing an overflow.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control byte reads the parameter value `CTL_RESET` (default 0x18), the counter reads 0, and `rst_req`, `nmi_req` and `irq_req` are low.
- R2: Address 0 holds the control byte and address 1 holds the counter. Control bit 5 is run-enable, and bits 2:0 choose a divide of 2^k, with k = 1, 6, 7, 9, 11, 13, 15, 17 for codes 0 to 7. With run-enable set, the counter reads n after 2^k·n clocks from the enabling write. A rollover from 0xFF to 0x00 sets the wrap flag, which is bit 7.
- R3: A control write takes effect only with key byte 0xA5, and a counter write only with key byte 0x5A. A write carrying any other key leaves the register unchanged.
- R4: Writing 1 to bit 7 never sets the flag. Writing 0 to bit 7 clears the flag only if an earlier control read returned the flag as 1. Any accepted control write uses up that read.
- R5: A control write with bit 5 = 0 clears the flag. While run-enable is 0, the counter reads 0, and counter writes have no effect.
- R6: With bit 6 = 1 (watchdog) and bit 4 = 1 (reset select), a rollover gives a one-cycle `rst_req` pulse in the cycle after the rollover edge. The flag reads 1 during that cycle and reads 0 from the next cycle on.
- R7: With bit 6 = 1 and bit 4 = 0, a rollover gives a one-cycle `nmi_req` pulse and the flag stays set. `irq_req` stays low in watchdog mode.
- R8: With bit 6 = 0 (interval), `irq_req` equals the flag ANDed with bit 3 (interrupt enable). No `rst_req` or `nmi_req` is raised.
- R9: If a rollover and a flag-clearing write land on the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for the register at `bus_addr` |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control byte, 1 = counter |
| bus_wdata | input | 16 | Key byte [15:8] and data byte [7:0] |
| bus_rdata | output | 8 | Contents of the addressed register (combinational) |
| rst_req | output | 1 | Internal reset request pulse |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| irq_req | output | 1 | Interval interrupt request level |

## Verification
The assertions assume the bus issues at most one strobe per cycle, and that the strobes and `bus_addr` are steady across each rising edge. The clear-rule property also relies on a flag clear being traceable to either a reset pulse or an accepted control write in the previous cycle. The bench drives every operation from one task per cycle, changing signals only on the falling edge and never asserting read and write together. Every rollover is produced by loading 0xFF at a known prescaler phase, so the edge where the wrap lands is known in advance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 17;
    localparam int SHIFT_W = 5;

    localparam logic [7:0] KEY_CTL = 8'hA5;
    localparam logic [7:0] KEY_CNT = 8'h5A;

    typedef enum logic {
        ADDR_CTL = 1'b0,
        ADDR_CNT = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic       dog;      // bit 6: 1 watchdog, 0 interval
        logic       run;      // bit 5: run-enable
        logic       rst_sel;  // bit 4: watchdog reset (1) or NMI (0)
        logic       ie;       // bit 3: interval interrupt enable
        logic [2:0] div_sel;  // bits 2:0: prescaler choice
    } ctl_t;

    function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 5'd1;
            3'd1:    return 5'd6;
            3'd2:    return 5'd7;
            3'd3:    return 5'd9;
            3'd4:    return 5'd11;
            3'd5:    return 5'd13;
            3'd6:    return 5'd15;
            default: return 5'd17;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int DIV_W = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);
    localparam int MASK_W = DIV_W + 1;

    logic [DIV_W-1:0]  pre_q;
    logic [MASK_W-1:0] wide_mask;
    logic [DIV_W-1:0]  mask;

    always_comb begin
        wide_mask = (MASK_W'(1) << div_shift(div_sel)) - MASK_W'(1);
        mask      = wide_mask[DIV_W-1:0];
        tick      = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + DIV_W'(1);
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    assign wrap = run && !load && tick && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst || !run)  count <= '0;
        else if (load)    count <= load_val;
        else if (tick)    count <= count + W'(1);
    end

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
    import wdt_pkg::*;
#(
    parameter logic [7:0] INIT = 8'h18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ok,
    input  logic [7:0] wdata,
    input  logic       rd_ctl,
    input  logic       wrap,
    output ctl_t       ctl,
    output logic       flag,
    output logic       rst_req,
    output logic       nmi_req
);
    logic armed;
    logic sw_clear;

    // Run-enable dropped, or an armed write of 0 to the flag bit.
    assign sw_clear = wr_ok && (!wdata[5] || (!wdata[7] && armed));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= ctl_t'(INIT[6:0]);
            flag    <= INIT[7];
            armed   <= 1'b0;
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            rst_req <= wrap && ctl.dog && ctl.rst_sel;
            nmi_req <= wrap && ctl.dog && !ctl.rst_sel;
            if (wr_ok) ctl <= ctl_t'(wdata[6:0]);

            if (wrap)          flag <= 1'b1;
            else if (rst_req)  flag <= 1'b0;
            else if (sw_clear) flag <= 1'b0;

            if (wr_ok || !flag)       armed <= 1'b0;
            else if (rd_ctl && flag)  armed <= 1'b1;
        end
    end

    assert_wrap_sets_R9: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    assert_clear_cause_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag) && !$past(rst_req)) |-> $past(wr_ok));

    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_nmi_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter logic [7:0] CTL_RESET = 8'h18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        rst_req,
    output logic        nmi_req,
    output logic        irq_req
);
    ctl_t             ctl;
    logic             flag;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic             ctl_wr_ok;
    logic             cnt_wr_ok;
    logic             rd_ctl;

    assign ctl_wr_ok = bus_wr && (reg_addr_e'(bus_addr) == ADDR_CTL)
                       && (bus_wdata[15:8] == KEY_CTL);
    assign cnt_wr_ok = bus_wr && (reg_addr_e'(bus_addr) == ADDR_CNT)
                       && (bus_wdata[15:8] == KEY_CNT);
    assign rd_ctl    = bus_rd && (reg_addr_e'(bus_addr) == ADDR_CTL);

    wdt_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .div_sel (ctl.div_sel),
        .tick    (tick)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl.run),
        .tick     (tick),
        .load     (cnt_wr_ok),
        .load_val (bus_wdata[CNT_W-1:0]),
        .count    (count),
        .wrap     (wrap)
    );

    wdt_ctl #(.INIT(CTL_RESET)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (ctl_wr_ok),
        .wdata   (bus_wdata[7:0]),
        .rd_ctl  (rd_ctl),
        .wrap    (wrap),
        .ctl     (ctl),
        .flag    (flag),
        .rst_req (rst_req),
        .nmi_req (nmi_req)
    );

    assign bus_rdata = (reg_addr_e'(bus_addr) == ADDR_CTL) ? {flag, 7'(ctl)} : count;
    assign irq_req   = flag && ctl.ie && !ctl.dog;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && tick && !cnt_wr_ok && count != 8'hFF)
        |=> (count == $past(count) + 8'd1));

    assert_irq_mode_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !rst_req);

endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_rd, bus_wr, bus_addr;
    logic [15:0] bus_wdata;
    logic [7:0]  bus_rdata;
    logic        rst_req, nmi_req, irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdt_timer uut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req)
    );

    typedef struct packed {
        logic        addr;
        logic [15:0] wdata;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 8'h18},  // R3 bad key
        '{1'b0, 16'hA503, 8'h03},  // R3 good key
        '{1'b0, 16'h5A44, 8'h03},  // R3 counter key on control
        '{1'b0, 16'hA59C, 8'h1C},  // R4 bit 7 not settable
        '{1'b1, 16'h5A77, 8'h00},  // R5 counter write while stopped
        '{1'b0, 16'hA55B, 8'h5B},  // R3 good key, new value
        '{1'b1, 16'hA510, 8'h00}   // R3 control key on counter
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(1'b0, v); check(v, 8'h18, "R1 ctl");
        peek(1'b1, v); check(v, 8'h00, "R1 count");
        check({5'd0, rst_req, nmi_req, irq_req}, 8'h00, "R1 outputs");

        // Table of writes and readbacks (R3 R4 R5)
        foreach (VECS[i]) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, v);
            check(v, VECS[i].exp, $sformatf("R3 vector %0d", i));
        end

        // R2 divide by 2: count 20 after 40 edges
        wr(1'b0, 16'hA500); wr(1'b0, 16'hA520);
        repeat (40) idle();
        rd(1'b1, v); check(v, 8'd20, "R2 div2");
        // R2 divide by 64
        wr(1'b0, 16'hA500); wr(1'b0, 16'hA521);
        repeat (127) idle();
        rd(1'b1, v); check(v, 8'd1, "R2 div64 at 127");
        rd(1'b1, v); check(v, 8'd2, "R2 div64 at 128");

        // R8 interval mode rollover
        wr(1'b0, 16'hA500); wr(1'b0, 16'hA528);
        wr(1'b1, 16'h5AFF);
        idle();
        peek(1'b0, v); check(v[7:0], 8'hA8, "R2 flag set on wrap");
        check({6'd0, irq_req, rst_req | nmi_req}, 8'h02, "R8 irq level");
        // R4 write 0 without arming read: flag stays; R8 ie off drops irq
        wr(1'b0, 16'hA520);
        peek(1'b0, v); check(v, 8'hA0, "R4 unarmed clear ignored");
        check({7'd0, irq_req}, 8'h00, "R8 irq masked");
        // R4 armed clear
        rd(1'b0, v); check(v, 8'hA0, "R4 read sees flag");
        wr(1'b0, 16'hA528);
        peek(1'b0, v); check(v, 8'h28, "R4 armed clear");

        // R9 wrap and clear on the same edge
        wr(1'b0, 16'hA500); wr(1'b0, 16'hA520);   // E0
        wr(1'b1, 16'h5AFF);                       // E1
        idle();                                   // E2 wrap
        rd(1'b0, v); check(v, 8'hA0, "R9 first wrap");  // E3 arms
        wr(1'b1, 16'h5AFF);                       // E4
        idle();                                   // E5
        wr(1'b0, 16'hA520);                       // E6 wrap + clear
        peek(1'b0, v); check(v, 8'hA0, "R9 set wins");

        // R5 stop clears flag and counter
        wr(1'b0, 16'hA500);
        peek(1'b0, v); check(v, 8'h00, "R5 stop clears flag");
        peek(1'b1, v); check(v, 8'h00, "R5 counter zero");

        // R6 watchdog reset
        wr(1'b0, 16'hA570); wr(1'b1, 16'h5AFF); idle();
        check({6'd0, rst_req, nmi_req}, 8'h02, "R6 reset pulse");
        peek(1'b0, v); check(v, 8'hF0, "R6 flag during pulse");
        idle();
        check({6'd0, rst_req, nmi_req}, 8'h00, "R6 pulse ends");
        peek(1'b0, v); check(v, 8'h70, "R6 flag cleared by reset");

        // R7 watchdog NMI
        wr(1'b0, 16'hA500); wr(1'b0, 16'hA568); wr(1'b1, 16'h5AFF); idle();
        check({5'd0, rst_req, nmi_req, irq_req}, 8'h02, "R7 nmi pulse");
        idle();
        check({5'd0, rst_req, nmi_req, irq_req}, 8'h00, "R7 nmi ends");
        peek(1'b0, v); check(v, 8'hE8, "R7 flag kept");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule